// File: doc/BRIEF.md
# Segment LCD Display Memory Controller

This block holds the display image of a multiplexed segment LCD controller: a bit memory of 32 columns by 4 rows. Each column feeds one segment output, and each row belongs to one backplane. A command front end, which has already decoded the host bus traffic, hands the block a drive mode, pointer loads, bank choices and a stream of 8-bit display bytes. The block scatters each byte over the rows that the mode uses, and then moves the write pointer past the columns it has just filled. Because the pointer advances by itself, bytes can follow one another with no further addressing.

A second, independent port lets the backplane sequencer read one column per cycle. It receives the row bits that the current mode drives. In the two low multiplex modes the memory holds a second bank in the spare rows. Separate bank controls for writing and for reading let a new image be built while the old one is shown.

Top module: `seglcd_dispram`

## Requirements
- R1: After reset every memory bit is 0 and the write pointer is column 0, so every column reads back 0.
- R2: In static mode (mode code 0) byte bit 7 goes to row 0 of the pointer column, and each lower bit goes to row 0 of the next column, up to bit 0 at pointer+7. Other rows are unchanged.
- R3: In 1:2 mode (mode code 1) the byte is split into pairs over four columns, starting at bit 7. Column pointer+i gets bit 7-2i in row 0 and bit 6-2i in row 1.
- R4: In 1:3 mode (mode code 2) column pointer+i gets bits 7-3i, 6-3i and 5-3i in rows 0, 1 and 2 for i = 0 and 1. Column pointer+2 gets bit 1 in row 0 and bit 0 in row 1, and its row 2 keeps its value. Row 3 is never written.
- R5: In 1:4 mode (mode code 3) column pointer gets bits 7..4 and column pointer+1 gets bits 3..0, with the higher bit in the lower row.
- R6: After each accepted byte the pointer moves forward by 8, 4, 3 or 2 columns in static, 1:2, 1:3 or 1:4 mode, modulo 32. Column addresses inside one byte wrap from 31 to 0 in the same way.
- R7: A pointer load sets the pointer to the load value for the next byte. A byte presented in the same cycle as a load is dropped and writes nothing.
- R8: With the write bank bit set, static mode writes row 2 in place of row 0, and 1:2 mode writes rows 2 and 3 in place of rows 0 and 1. The bit has no effect in 1:3 and 1:4 modes.
- R9: The readout gives row k of the addressed column on bit k for the rows the mode uses (row 0; rows 0-1; rows 0-2; rows 0-3), and 0 on the unused bits. With the read bank bit set, static mode shows row 2 on bit 0, and 1:2 mode shows rows 2 and 3 on bits 0 and 1. The read bank bit has no effect in 1:3 and 1:4 modes.
- R10: A readout of a column in the same cycle as a write to it returns the contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| ptr_load_i | input | 1 | Load the write pointer this cycle |
| ptr_val_i | input | 5 | Pointer load value |
| wr_bank_i | input | 1 | Write bank select (static and 1:2 only) |
| rd_bank_i | input | 1 | Read bank select (static and 1:2 only) |
| data_valid_i | input | 1 | A display byte is present |
| data_i | input | 8 | Display byte |
| rd_col_i | input | 5 | Readout column address |
| rd_bits_o | output | 4 | Row bits of the addressed column for the current mode |

## Verification
Bytes of mixed bit patterns are written in every mode, and the whole memory is then scanned in 1:4 readout, which shows all four rows. This tells a wrong bit order or row choice apart from a wrong column span. Writes that start near column 31 show whether column addresses wrap. A 1:3 pass over a memory filled with ones shows that row 2 of every third column and row 3 are left alone. Writes and reads with each bank bit set, in every mode, show that the remap happens in the low modes and is ignored elsewhere. A long pseudo-random stream of modes, banks, loads and bytes is then compared, clock by clock, against a model of the bit placement.

// File: rtl/seglcd_pkg.sv
package seglcd_pkg;

  localparam int ROWS   = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_DUP    = 2'd1,
    MODE_TRI    = 2'd2,
    MODE_QUAD   = 2'd3
  } drive_mode_e;

  // Columns consumed by one byte in a mode
  function automatic logic [3:0] unit_step(drive_mode_e m);
    case (m)
      MODE_STATIC: unit_step = 4'd8;
      MODE_DUP:    unit_step = 4'd4;
      MODE_TRI:    unit_step = 4'd3;
      default:     unit_step = 4'd2;
    endcase
  endfunction

  // For column offset k from the pointer: {row write mask, row data}
  function automatic logic [7:0] place_unit(drive_mode_e m, logic bank,
                                            logic [BYTE_W-1:0] b, int k);
    logic [ROWS-1:0] mk;
    logic [ROWS-1:0] dt;
    int base;
    int idx;
    mk = '0;
    dt = '0;
    base = (bank && (m == MODE_STATIC || m == MODE_DUP)) ? 2 : 0;
    case (m)
      MODE_STATIC: begin
        if (k < 8) begin
          idx = 7 - k;
          mk[base[1:0]] = 1'b1;
          dt[base[1:0]] = b[idx[2:0]];
        end
      end
      MODE_DUP: begin
        if (k < 4) begin
          for (int r = 0; r < 2; r++) begin
            idx = 7 - 2 * k - r;
            mk[2'(base + r)] = 1'b1;
            dt[2'(base + r)] = b[idx[2:0]];
          end
        end
      end
      MODE_TRI: begin
        if (k < 3) begin
          for (int r = 0; r < 3; r++) begin
            idx = 7 - 3 * k - r;
            if (idx >= 0) begin
              mk[r[1:0]] = 1'b1;
              dt[r[1:0]] = b[idx[2:0]];
            end
          end
        end
      end
      default: begin
        if (k < 2) begin
          for (int r = 0; r < 4; r++) begin
            idx = 7 - 4 * k - r;
            mk[r[1:0]] = 1'b1;
            dt[r[1:0]] = b[idx[2:0]];
          end
        end
      end
    endcase
    place_unit = {mk, dt};
  endfunction

  // Rows of a stored column presented to the sequencer
  function automatic logic [ROWS-1:0] read_map(drive_mode_e m, logic bank,
                                               logic [ROWS-1:0] col);
    case (m)
      MODE_STATIC: read_map = {3'b000, bank ? col[2] : col[0]};
      MODE_DUP:    read_map = {2'b00, bank ? col[3:2] : col[1:0]};
      MODE_TRI:    read_map = {1'b0, col[2:0]};
      default:     read_map = col;
    endcase
  endfunction

endpackage

// File: rtl/seglcd_ptr.sv
module seglcd_ptr #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             adv_i,
  input  logic [3:0]       step_i,
  output logic [PTR_W-1:0] ptr_o
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (adv_i)  ptr_q <= ptr_q + PTR_W'(step_i);
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/seglcd_wr_map.sv
module seglcd_wr_map
  import seglcd_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int PTR_W = $clog2(COLS)
) (
  input  drive_mode_e                mode_i,
  input  logic                       bank_i,
  input  logic [BYTE_W-1:0]          byte_i,
  input  logic                       wr_en_i,
  input  logic [PTR_W-1:0]           ptr_i,
  output logic [COLS-1:0][ROWS-1:0]  mask_o,
  output logic [COLS-1:0][ROWS-1:0]  data_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [PTR_W-1:0] off;
    logic [7:0]       unit;
    assign off       = PTR_W'(c) - ptr_i;
    assign unit      = place_unit(mode_i, bank_i, byte_i, int'(off));
    assign mask_o[c] = wr_en_i ? unit[7:4] : '0;
    assign data_o[c] = unit[3:0];
  end

endmodule

// File: rtl/seglcd_rd_sel.sv
module seglcd_rd_sel
  import seglcd_pkg::*;
(
  input  drive_mode_e     mode_i,
  input  logic            bank_i,
  input  logic [ROWS-1:0] col_i,
  output logic [ROWS-1:0] bits_o
);

  assign bits_o = read_map(mode_i, bank_i, col_i);

endmodule

// File: rtl/seglcd_dispram.sv
module seglcd_dispram
  import seglcd_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int PTR_W = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               ptr_load_i,
  input  logic [PTR_W-1:0]   ptr_val_i,
  input  logic               wr_bank_i,
  input  logic               rd_bank_i,
  input  logic               data_valid_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [PTR_W-1:0]   rd_col_i,
  output logic [ROWS-1:0]    rd_bits_o
);

  drive_mode_e mode;
  assign mode = drive_mode_e'(mode_i);

  // Named internal events
  logic                      wr_fire;
  logic [PTR_W-1:0]          ptr_q;
  logic [COLS-1:0][ROWS-1:0] wr_mask;
  logic [COLS-1:0][ROWS-1:0] wr_data;
  logic [COLS-1:0]           col_hit;
  logic [COLS-1:0]           row3_we;
  logic [COLS-1:0][ROWS-1:0] ram_q;

  assign wr_fire = data_valid_i && !ptr_load_i;

  seglcd_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load_i),
    .load_val_i (ptr_val_i),
    .adv_i      (wr_fire),
    .step_i     (unit_step(mode)),
    .ptr_o      (ptr_q)
  );

  seglcd_wr_map #(.COLS(COLS), .PTR_W(PTR_W)) u_wr_map (
    .mode_i  (mode),
    .bank_i  (wr_bank_i),
    .byte_i  (data_i),
    .wr_en_i (wr_fire),
    .ptr_i   (ptr_q),
    .mask_o  (wr_mask),
    .data_o  (wr_data)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_evt
    assign col_hit[c] = |wr_mask[c];
    assign row3_we[c] = wr_mask[c][3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        for (int r = 0; r < ROWS; r++) begin
          if (wr_mask[c][r]) ram_q[c][r] <= wr_data[c][r];
        end
      end
    end
  end

  seglcd_rd_sel u_rd_sel (
    .mode_i (mode),
    .bank_i (rd_bank_i),
    .col_i  (ram_q[rd_col_i]),
    .bits_o (rd_bits_o)
  );

endmodule

// File: rtl/seglcd_dispram_chk.sv
module seglcd_dispram_chk #(
  parameter int COLS  = 32,
  parameter int PTR_W = $clog2(COLS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             ptr_load_i,
  input logic [PTR_W-1:0] ptr_val_i,
  input logic             data_valid_i,
  input logic [PTR_W-1:0] ptr_q,
  input logic [COLS-1:0]  col_hit,
  input logic [COLS-1:0]  row3_we,
  input logic [3:0]       rd_bits_o
);

  logic [PTR_W-1:0] exp_step;
  always_comb begin
    case (mode_i)
      2'd0:    exp_step = PTR_W'(8);
      2'd1:    exp_step = PTR_W'(4);
      2'd2:    exp_step = PTR_W'(3);
      default: exp_step = PTR_W'(2);
    endcase
  end

  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_i |=> ptr_q == $past(ptr_val_i));

  // R7
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_i |-> col_hit == '0);

  // R6
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_i && !ptr_load_i) |=> ptr_q == PTR_W'($past(ptr_q) + $past(exp_step)));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_valid_i && !ptr_load_i) |=> $stable(ptr_q));

  // R6
  col_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_i && !ptr_load_i) |-> $countones(col_hit) == int'(exp_step));

  // R4
  tri_row3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> row3_we == '0);

  // R9
  rd_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |-> rd_bits_o[3:1] == 3'b000);

  // R9
  rd_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> rd_bits_o[3:2] == 2'b00);

  // R9
  rd_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> rd_bits_o[3] == 1'b0);

endmodule

bind seglcd_dispram seglcd_dispram_chk #(.COLS(COLS), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .ptr_load_i   (ptr_load_i),
  .ptr_val_i    (ptr_val_i),
  .data_valid_i (data_valid_i),
  .ptr_q        (ptr_q),
  .col_hit      (col_hit),
  .row3_we      (row3_we),
  .rd_bits_o    (rd_bits_o)
);

// File: tb/seglcd_dispram_bench.sv
module seglcd_dispram_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       ld = 1'b0;
  logic [4:0] lv = '0;
  logic       wb = 1'b0;
  logic       rb = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] din = '0;
  logic [4:0] rcol = '0;
  logic [3:0] rbits;

  int total = 0;
  int fails = 0;

  // Reference model
  logic [3:0] mram [32];
  int mptr = 0;

  always #2 clk = ~clk;

  seglcd_dispram u_seglcd_dispram (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .ptr_load_i   (ld),
    .ptr_val_i    (lv),
    .wr_bank_i    (wb),
    .rd_bank_i    (rb),
    .data_valid_i (vld),
    .data_i       (din),
    .rd_col_i     (rcol),
    .rd_bits_o    (rbits)
  );

  function automatic logic [3:0] model_read(int col);
    logic [3:0] e;
    int n;
    int sh;
    e = '0;
    n = int'(mode) + 1;
    sh = (rb && mode < 2) ? 2 : 0;
    for (int i = 0; i < n; i++) e[i] = mram[col][i + sh];
    return e;
  endfunction

  task automatic model_apply();
    int per;
    int col;
    int row;
    if (ld) begin
      mptr = int'(lv);
    end else if (vld) begin
      per = int'(mode) + 1;           // bits per column
      for (int j = 0; j < 8; j++) begin
        col = (mptr + j / per) % 32;
        row = j % per;
        if (wb && mode < 2) row = row + 2;
        mram[col][row] = din[7 - j];
      end
      case (mode)
        2'd0: mptr = (mptr + 8) % 32;
        2'd1: mptr = (mptr + 4) % 32;
        2'd2: mptr = (mptr + 3) % 32;
        default: mptr = (mptr + 2) % 32;
      endcase
    end
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: col %0d actual %h expected %h", tag, rcol, act, exp);
    end
  endtask

  // One clock: drive, compare readout against the pre-edge model, advance.
  task automatic cyc(logic [1:0] m, logic w, logic r, logic l, logic [4:0] v,
                     logic d, logic [7:0] b, logic [4:0] rc, string tag);
    mode = m; wb = w; rb = r; ld = l; lv = v; vld = d; din = b; rcol = rc;
    #1;
    check(tag, rbits, model_read(int'(rc)));
    @(posedge clk);
    model_apply();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m, logic w, logic [7:0] b, string tag);
    cyc(m, w, 1'b0, 1'b0, 5'd0, 1'b1, b, 5'd0, tag);
  endtask

  task automatic load(logic [4:0] v, string tag);
    cyc(mode, 1'b0, 1'b0, 1'b1, v, 1'b0, 8'h00, 5'd0, tag);
  endtask

  task automatic scan(logic [1:0] m, logic r, string tag);
    for (int c = 0; c < 32; c++)
      cyc(m, 1'b0, r, 1'b0, 5'd0, 1'b0, 8'h00, 5'(c), tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int c = 0; c < 32; c++) mram[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all columns zero after reset, viewed with all rows
    scan(2'd3, 1'b0, "R1");
    // R1: pointer is 0 -> first static byte lands at column 0
    wr(2'd0, 1'b0, 8'h81, "R1");
    scan(2'd3, 1'b0, "R1");

    // R7 load, R2 static placement, R6 wrap inside the byte
    load(5'd28, "R7");
    wr(2'd0, 1'b0, 8'hA5, "R2");
    scan(2'd3, 1'b0, "R2");
    wr(2'd0, 1'b0, 8'h3C, "R6");      // pointer now at 4
    scan(2'd0, 1'b0, "R6");

    // R3 1:2 pairs
    load(5'd30, "R7");
    wr(2'd1, 1'b0, 8'h9B, "R3");
    wr(2'd1, 1'b0, 8'h62, "R3");
    scan(2'd3, 1'b0, "R3");
    scan(2'd1, 1'b0, "R3");

    // R4 1:3 over a memory of ones
    load(5'd10, "R7");
    for (int i = 0; i < 4; i++) wr(2'd3, 1'b0, 8'hFF, "R5");
    load(5'd10, "R7");
    wr(2'd2, 1'b0, 8'h00, "R4");
    wr(2'd2, 1'b0, 8'h24, "R4");
    scan(2'd3, 1'b0, "R4");
    scan(2'd2, 1'b0, "R4");

    // R5 1:4 nibbles, wrap at 31
    load(5'd31, "R7");
    wr(2'd3, 1'b0, 8'h5E, "R5");
    wr(2'd3, 1'b0, 8'hC3, "R5");
    scan(2'd3, 1'b0, "R5");

    // R8 write bank remap in low modes, ignored in high modes
    load(5'd16, "R8");
    wr(2'd0, 1'b1, 8'hF0, "R8");
    wr(2'd1, 1'b1, 8'h6C, "R8");
    wr(2'd2, 1'b1, 8'hB7, "R8");
    wr(2'd3, 1'b1, 8'h1E, "R8");
    scan(2'd3, 1'b0, "R8");

    // R9 readout per mode and read bank
    scan(2'd0, 1'b1, "R9");
    scan(2'd1, 1'b1, "R9");
    scan(2'd2, 1'b1, "R9");
    scan(2'd3, 1'b1, "R9");

    // R7 byte in the same cycle as a load is dropped
    cyc(2'd3, 1'b0, 1'b0, 1'b1, 5'd5, 1'b1, 8'hFF, 5'd5, "R7");
    scan(2'd3, 1'b0, "R7");
    wr(2'd3, 1'b0, 8'h00, "R7");      // lands at the loaded column 5
    scan(2'd3, 1'b0, "R7");

    // R10 read of the column written in the same cycle returns old data
    load(5'd8, "R10");
    cyc(2'd3, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 8'hA9, 5'd8, "R10");
    cyc(2'd3, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 8'h57, 5'd10, "R10");
    cyc(2'd3, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 8'h00, 5'd10, "R10");

    // R6 long pseudo-random stream, compared every clock
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[1:0], lfsr[2], lfsr[3], (lfsr[7:4] == 4'd0), lfsr[12:8],
          lfsr[13] | lfsr[14], {lfsr[7:0] ^ lfsr[15:8]}, lfsr[15:11], "R6");
    end
    scan(2'd3, 1'b0, "R6");

    finish_run();
  end

endmodule